// File: doc/BRIEF.md
# Legacy Replacement Interrupt Router

This block places the interrupt requests of a group of event timers onto a bank of 32 interrupt lines. It also merges in two interrupt inputs from outside the timer group: one from an interval timer and one from a real-time clock. Each timer supplies a 5-bit line number, a request, and a trigger type. A level-type request holds its line high. An edge-type request places a single-cycle pulse on its line. When several sources select the same line, they are ORed together. Every line is driven from a register.

A legacy-mode input is taken from the global configuration. While it is set, timer 0 is forced onto the interval-timer line and timer 1 onto the clock line, and the two external inputs are cut off. The block keeps tracking the clock input's level during legacy mode. When legacy mode ends, the clock line returns at once to that level. The interval-timer line stays low for one more cycle before it follows its input again. A separate output tells the interval timer whether it may drive its line.

Top module: `lir_router`

## Requirements
- R1: Outside legacy mode, each timer's request appears on the line numbered by its 5-bit route field (bits [5i+4:5i] of the route bus for timer i), one clock edge after the request.
- R2: In legacy mode, timer 0 drives line PIT_LINE (default 0) and timer 1 drives line RTC_LINE (default 8), whatever their route fields hold.
- R3: Timers 2 and above use their route field whether or not legacy mode is set.
- R4: Outside legacy mode, the interval-timer input drives line PIT_LINE and the clock input drives line RTC_LINE. Each passes through one input register and the output register, so it appears two edges after it is sampled.
- R5: While legacy mode is set, neither external input reaches any line. On the edge where legacy mode is first seen, lines PIT_LINE and RTC_LINE go low unless a timer drives them. From the following edge, the interval-timer enable output is low; it equals the inverse of legacy mode as sampled one edge before.
- R6: When legacy mode clears, line PIT_LINE stays low for one further edge while the enable output rises. Line RTC_LINE takes the clock input level that was registered during legacy mode, on the first edge after the clear.
- R7: A level-type request (trigger input 1) keeps its line high on every edge for which the request was high, and the line drops one edge after the request falls.
- R8: An edge-type request (trigger input 0) gives a one-cycle pulse after each rising request. A request that stays high gives no further pulses.
- R9: A line is high when any source routed to it is active.
- R10: After reset, all lines are low, the enable output is high, and the stored clock level and the request history are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode_i | input | 1 | Legacy replacement mode from global configuration |
| tmr_req_i | input | NUM_TIMERS | Interrupt request per timer |
| tmr_level_i | input | NUM_TIMERS | Trigger type per timer: 1 level, 0 edge |
| tmr_route_i | input | NUM_TIMERS*5 | 5-bit line number per timer, timer i at bits [5i+4:5i] |
| pit_irq_i | input | 1 | Interrupt input from the external interval timer |
| rtc_irq_i | input | 1 | Interrupt input from the real-time clock |
| irq_o | output | 32 | Registered interrupt lines |
| pit_en_o | output | 1 | Interval timer may drive its line |

## Verification
The bench builds the router with NUM_TIMERS set to 5, so that timers 0 and 1 (overridden in legacy mode) and several plain timers (2 to 4, which always follow their route field) are all present. The line numbers keep their defaults of 0 and 8. With five timers, two or more sources can share one line, and a plain timer can be routed onto line 0 or 8 while the legacy override or an external input also drives it. This exercises the OR merge on exactly the lines where the legacy rules apply.

// File: rtl/lir_pkg.sv
package lir_pkg;

    localparam int unsigned LIR_LINES = 32;
    localparam int unsigned LIR_SEL_W = $clog2(LIR_LINES);

    typedef logic [LIR_SEL_W-1:0] line_sel_t;
    typedef logic [LIR_LINES-1:0] line_vec_t;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    // One-hot vector for a selected line, empty when inactive.
    function automatic line_vec_t sel_to_vec(line_sel_t sel, logic active);
        line_vec_t v;
        v = '0;
        if (active) begin
            v[sel] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/lir_route_sel.sv
module lir_route_sel
    import lir_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 3,
    parameter int unsigned PIT_LINE   = 0,
    parameter int unsigned RTC_LINE   = 8
) (
    input  logic                              legacy_mode_i,
    input  logic [NUM_TIMERS*LIR_SEL_W-1:0]   route_i,
    output line_sel_t [NUM_TIMERS-1:0]        eff_sel_o
);

    localparam line_sel_t PIT_SEL = line_sel_t'(PIT_LINE);
    localparam line_sel_t RTC_SEL = line_sel_t'(RTC_LINE);

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_sel
        line_sel_t field;
        assign field = route_i[i*LIR_SEL_W +: LIR_SEL_W];
        if (i == 0) begin : g_t0
            assign eff_sel_o[i] = legacy_mode_i ? PIT_SEL : field;
        end else if (i == 1) begin : g_t1
            assign eff_sel_o[i] = legacy_mode_i ? RTC_SEL : field;
        end else begin : g_tn
            assign eff_sel_o[i] = field;
        end
    end

endmodule

// File: rtl/lir_src_shape.sv
module lir_src_shape
    import lir_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_TIMERS-1:0] req_i,
    input  logic [NUM_TIMERS-1:0] level_i,
    output logic [NUM_TIMERS-1:0] fire_o
);

    logic [NUM_TIMERS-1:0] req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= req_i;
        end
    end

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_shape
        trig_e trig;
        assign trig      = trig_e'(level_i[i]);
        assign fire_o[i] = (trig == TRIG_LEVEL) ? req_i[i]
                                                : (req_i[i] & ~req_q[i]);
    end

endmodule

// File: rtl/lir_legacy_in.sv
module lir_legacy_in (
    input  logic clk,
    input  logic rst,
    input  logic legacy_mode_i,
    input  logic pit_irq_i,
    input  logic rtc_irq_i,
    output logic pit_drive_o,
    output logic rtc_drive_o,
    output logic pit_en_o
);

    logic pit_q;
    logic rtc_q;
    logic pit_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pit_q    <= 1'b0;
            rtc_q    <= 1'b0;
            pit_en_q <= 1'b1;
        end else begin
            pit_q    <= pit_irq_i;
            rtc_q    <= rtc_irq_i;
            pit_en_q <= ~legacy_mode_i;
        end
    end

    assign pit_drive_o = pit_en_q & ~legacy_mode_i & pit_q;
    assign rtc_drive_o = ~legacy_mode_i & rtc_q;
    assign pit_en_o    = pit_en_q;

endmodule

// File: rtl/lir_router.sv
module lir_router
    import lir_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 3,
    parameter int unsigned PIT_LINE   = 0,
    parameter int unsigned RTC_LINE   = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            legacy_mode_i,
    input  logic [NUM_TIMERS-1:0]           tmr_req_i,
    input  logic [NUM_TIMERS-1:0]           tmr_level_i,
    input  logic [NUM_TIMERS*LIR_SEL_W-1:0] tmr_route_i,
    input  logic                            pit_irq_i,
    input  logic                            rtc_irq_i,
    output logic [LIR_LINES-1:0]            irq_o,
    output logic                            pit_en_o
);

    line_sel_t [NUM_TIMERS-1:0] eff_sel;
    logic [NUM_TIMERS-1:0]      fire;
    logic                       pit_drive;
    logic                       rtc_drive;
    line_vec_t                  merged;
    line_vec_t                  irq_q;

    lir_route_sel #(
        .NUM_TIMERS (NUM_TIMERS),
        .PIT_LINE   (PIT_LINE),
        .RTC_LINE   (RTC_LINE)
    ) u_sel (
        .legacy_mode_i (legacy_mode_i),
        .route_i       (tmr_route_i),
        .eff_sel_o     (eff_sel)
    );

    lir_src_shape #(
        .NUM_TIMERS (NUM_TIMERS)
    ) u_shape (
        .clk     (clk),
        .rst     (rst),
        .req_i   (tmr_req_i),
        .level_i (tmr_level_i),
        .fire_o  (fire)
    );

    lir_legacy_in u_leg (
        .clk           (clk),
        .rst           (rst),
        .legacy_mode_i (legacy_mode_i),
        .pit_irq_i     (pit_irq_i),
        .rtc_irq_i     (rtc_irq_i),
        .pit_drive_o   (pit_drive),
        .rtc_drive_o   (rtc_drive),
        .pit_en_o      (pit_en_o)
    );

    always_comb begin
        merged = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            merged = merged | sel_to_vec(eff_sel[i], fire[i]);
        end
        merged[PIT_LINE] = merged[PIT_LINE] | pit_drive;
        merged[RTC_LINE] = merged[RTC_LINE] | rtc_drive;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q <= merged;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/lir_router_chk.sv
module lir_router_chk #(
    parameter int unsigned NUM_TIMERS = 3,
    parameter int unsigned PIT_LINE   = 0,
    parameter int unsigned RTC_LINE   = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  legacy_mode_i,
    input logic [NUM_TIMERS-1:0] tmr_req_i,
    input logic [NUM_TIMERS-1:0] tmr_level_i,
    input logic [31:0]           irq_o,
    input logic                  pit_en_o
);

    AST_PIT_EN_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pit_en_o == !$past(legacy_mode_i)));  // R5

    AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (legacy_mode_i && tmr_req_i == '0) |=> (irq_o == '0));  // R5

    AST_LEGACY_T0_LINE: assert property (@(posedge clk) disable iff (rst)
        (legacy_mode_i && tmr_req_i[0] && tmr_level_i[0]) |=> irq_o[PIT_LINE]);  // R2

    AST_LEGACY_T1_LINE: assert property (@(posedge clk) disable iff (rst)
        (legacy_mode_i && tmr_req_i[1] && tmr_level_i[1]) |=> irq_o[RTC_LINE]);  // R2

    AST_LEAVE_PIT_LOW: assert property (@(posedge clk) disable iff (rst)
        ($fell(legacy_mode_i) && !$past(rst) && tmr_req_i == '0)
        |=> !irq_o[PIT_LINE]);  // R6

endmodule

bind lir_router lir_router_chk #(
    .NUM_TIMERS (NUM_TIMERS),
    .PIT_LINE   (PIT_LINE),
    .RTC_LINE   (RTC_LINE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .legacy_mode_i (legacy_mode_i),
    .tmr_req_i     (tmr_req_i),
    .tmr_level_i   (tmr_level_i),
    .irq_o         (irq_o),
    .pit_en_o      (pit_en_o)
);

// File: tb/lir_router_test.sv
module lir_router_test;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 5;
    localparam int PL         = 0;
    localparam int RL         = 8;

    typedef logic [NT-1:0][4:0] route_arr_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              legacy = 1'b0;
    logic [NT-1:0]     req = '0;
    logic [NT-1:0]     lvl = '0;
    route_arr_t        routes = '0;
    logic              pit = 1'b0;
    logic              rtc = 1'b0;
    logic [31:0]       irq;
    logic              pit_en;

    int compared = 0;
    int mismatched = 0;

    // bench model state
    logic          m_pen = 1'b1;
    logic          m_pq = 1'b0;
    logic          m_rq = 1'b0;
    logic [NT-1:0] m_reqp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lir_router #(
        .NUM_TIMERS (NT),
        .PIT_LINE   (PL),
        .RTC_LINE   (RL)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .legacy_mode_i (legacy),
        .tmr_req_i     (req),
        .tmr_level_i   (lvl),
        .tmr_route_i   (routes),
        .pit_irq_i     (pit),
        .rtc_irq_i     (rtc),
        .irq_o         (irq),
        .pit_en_o      (pit_en)
    );

    function automatic logic [31:0] model_lines(
        logic lg, logic pen, logic pq, logic rq,
        logic [NT-1:0] rq_now, logic [NT-1:0] lv, logic [NT-1:0] rp,
        route_arr_t rt);
        logic [31:0] v;
        logic        active;
        int          line;
        v = '0;
        for (int i = 0; i < NT; i++) begin
            active = lv[i] ? rq_now[i] : (rq_now[i] && !rp[i]);
            if (lg && i == 0)      line = PL;
            else if (lg && i == 1) line = RL;
            else                   line = int'(rt[i]);
            if (active) v[line] = 1'b1;
        end
        if (pen && !lg && pq) v[PL] = 1'b1;
        if (!lg && rq)        v[RL] = 1'b1;
        return v;
    endfunction

    task automatic compare(string tag, logic [31:0] exp_irq, logic exp_en);
        compared++;
        if (irq !== exp_irq) begin
            mismatched++;
            $display("FAIL %s lines actual %h expected %h", tag, irq, exp_irq);
        end
        compared++;
        if (pit_en !== exp_en) begin
            mismatched++;
            $display("FAIL %s enable actual %b expected %b", tag, pit_en, exp_en);
        end
    endtask

    // Called at a falling edge: apply inputs, predict, advance one cycle.
    task automatic step(string tag, logic lg, logic p, logic r,
                        logic [NT-1:0] rq_now, logic [NT-1:0] lv, route_arr_t rt);
        logic [31:0] e_irq;
        logic        e_en;
        legacy = lg; pit = p; rtc = r; req = rq_now; lvl = lv; routes = rt;
        e_irq  = model_lines(lg, m_pen, m_pq, m_rq, rq_now, lv, m_reqp, rt);
        e_en   = !lg;
        m_pen  = !lg; m_pq = p; m_rq = r; m_reqp = rq_now;
        @(negedge clk);
        compare(tag, e_irq, e_en);
    endtask

    initial begin
        route_arr_t rt;
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: state right after reset
        compare("R10", 32'h0, 1'b1);

        // R10: remembered clock level starts at 0 although the input is high
        step("R10", 1'b0, 1'b0, 1'b1, 5'b00000, 5'b00000, rt);
        step("R4",  1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, rt);
        step("R4",  1'b0, 1'b1, 1'b0, 5'b00000, 5'b00000, rt);
        step("R4",  1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, rt);
        step("R4",  1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, rt);

        // R1 / R7: timer 2 level on line 17, held then released
        rt[2] = 5'd17;
        step("R1", 1'b0, 1'b0, 1'b0, 5'b00100, 5'b00100, rt);
        step("R7", 1'b0, 1'b0, 1'b0, 5'b00100, 5'b00100, rt);
        step("R7", 1'b0, 1'b0, 1'b0, 5'b00100, 5'b00100, rt);
        step("R7", 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00100, rt);

        // R8: timer 3 edge on line 31, request held high
        rt[3] = 5'd31;
        step("R8", 1'b0, 1'b0, 1'b0, 5'b01000, 5'b00000, rt);
        step("R8", 1'b0, 1'b0, 1'b0, 5'b01000, 5'b00000, rt);
        step("R8", 1'b0, 1'b0, 1'b0, 5'b01000, 5'b00000, rt);
        step("R8", 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, rt);
        step("R8", 1'b0, 1'b0, 1'b0, 5'b01000, 5'b00000, rt);

        // R9: timers 2 and 4 share line 5; timer 3 onto line 8 with clock input
        rt[2] = 5'd5; rt[4] = 5'd5; rt[3] = 5'd8;
        step("R9", 1'b0, 1'b0, 1'b1, 5'b10100, 5'b10100, rt);
        step("R9", 1'b0, 1'b0, 1'b1, 5'b00100, 5'b00100, rt);
        step("R9", 1'b0, 1'b0, 1'b0, 5'b01000, 5'b00000, rt);
        step("R9", 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, rt);

        // R5: enter legacy with both external inputs high
        step("R4", 1'b0, 1'b1, 1'b1, 5'b00000, 5'b00000, rt);
        step("R4", 1'b0, 1'b1, 1'b1, 5'b00000, 5'b00000, rt);
        step("R5", 1'b1, 1'b1, 1'b1, 5'b00000, 5'b00000, rt);
        step("R5", 1'b1, 1'b1, 1'b1, 5'b00000, 5'b00000, rt);

        // R2 / R3: legacy overrides timers 0 and 1 only
        rt[0] = 5'd3; rt[1] = 5'd4; rt[4] = 5'd20;
        step("R2", 1'b1, 1'b1, 1'b0, 5'b00011, 5'b00011, rt);
        step("R2", 1'b1, 1'b1, 1'b0, 5'b00001, 5'b00011, rt);
        step("R3", 1'b1, 1'b1, 1'b0, 5'b10000, 5'b10000, rt);
        step("R3", 1'b1, 1'b1, 1'b1, 5'b00000, 5'b00000, rt);

        // R6: leave legacy, clock line restored, line 0 held low one edge
        step("R6", 1'b0, 1'b1, 1'b1, 5'b00000, 5'b00000, rt);
        step("R6", 1'b0, 1'b1, 1'b1, 5'b00000, 5'b00000, rt);
        step("R6", 1'b0, 1'b1, 1'b1, 5'b00000, 5'b00000, rt);
        step("R1", 1'b0, 1'b0, 1'b0, 5'b00011, 5'b00011, rt);

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            route_arr_t rr;
            logic lg;
            for (int k = 0; k < NT; k++) begin
                rr[k] = ($urandom % 4 == 0) ? (($urandom % 2 == 0) ? 5'd0 : 5'd8)
                                            : 5'($urandom);
            end
            lg = ($urandom % 8) < 3;
            step(lg ? "R2" : "R1", lg, 1'($urandom), 1'($urandom),
                 NT'($urandom), NT'($urandom), rr);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule